// File: doc/BRIEF.md
# Edge and Pulse-Width Input Capture

This block timestamps events on an asynchronous input pin against its own free-running up-counter. The pin is brought into the clock domain by a flop chain, and edges are found on the synchronised level. A 2-bit selector picks what counts as an event: nothing, a rising edge, a falling edge, or a complete high pulse. In the edge modes the capture register takes the counter value at the event. In pulse mode a rising edge starts a measurement and the following falling edge stores the elapsed count, which is the pulse width.

The capture register keeps its value between events. A sticky capture flag records that a capture happened. In stop mode that flag also locks the register against later events until software clears the flag. Pulse mode always runs as if continuous mode were selected. A separate sticky flag records each wrap of the counter. Both flags are cleared by one-cycle write-one strobes. The synchronised pin level is reported as status.

Top module: `pulse_capture_unit`

## Requirements
- R1: With ev_sel = 2'b01, a rising edge on pin_raw loads capture_val with the value count_val holds in the cycle the edge is detected. Detection happens two clock edges after the pin changes, so the stored value is the count seen before the change plus two.
- R2: capture_val changes only when a capture is accepted. It does not follow the counter while waiting for an event.
- R3: With ev_sel = 2'b10, a falling edge is the event and rising edges are ignored, with the same timing as R1.
- R4: With ev_sel = 2'b00, no edge changes capture_val or sets cap_flag.
- R5: With ev_sel = 2'b11, a rising edge starts a measurement and the next falling edge stores the number of counter increments between the two detected edges. A lone rising edge stores nothing.
- R6: In pulse mode stop_mode has no effect. Every completed pulse overwrites capture_val, even while cap_flag is set.
- R7: With stop_mode = 1 in an edge mode, an event arriving while cap_flag is set is ignored. If clr_cap is asserted in the same cycle as the event, the event is accepted and cap_flag stays set.
- R8: With stop_mode = 0, every event overwrites capture_val.
- R9: cap_flag becomes 1 on each accepted capture, stays 1, and returns to 0 one cycle after a clr_cap strobe in which no capture is accepted.
- R10: ovf_flag becomes 1 when count_val wraps from all ones to zero. It stays set until a clr_ovf strobe. A wrap in the same cycle as clr_ovf leaves it set. count_val advances by one per cycle only while count_en is 1.
- R11: pin_level follows pin_raw through two flops: a change shows two clock edges later.
- R12: While rst is high, count_val, capture_val, cap_flag, ovf_flag and pin_level are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| count_en | input | 1 | Counter advance enable |
| pin_raw | input | 1 | Asynchronous input pin |
| ev_sel | input | 2 | Event type: 00 off, 01 rise, 10 fall, 11 pulse width |
| stop_mode | input | 1 | 1 = lock after first capture, 0 = continuous |
| clr_cap | input | 1 | Write-one strobe clearing cap_flag |
| clr_ovf | input | 1 | Write-one strobe clearing ovf_flag |
| count_val | output | 16 | Running counter value |
| capture_val | output | 16 | Captured timestamp or pulse width |
| pin_level | output | 1 | Synchronised pin level |
| cap_flag | output | 1 | Sticky capture-occurred flag |
| ovf_flag | output | 1 | Sticky counter-wrap flag |

## Verification
Two collisions matter here. The first is a capture event meeting a clr_cap strobe while stop mode is locked. The second is a counter wrap meeting a clr_ovf strobe. For the first, the bench times clr_cap to the exact cycle in which the synchronised rising edge is detected. It then expects the new timestamp and a flag that is still set. For the second, the bench holds count_en low with the counter at all ones, then raises count_en and clr_ovf together. It expects the counter at zero with ovf_flag still set.

// File: rtl/pcu_pkg.sv
package pcu_pkg;

    typedef enum logic [1:0] {
        EV_OFF   = 2'b00,
        EV_RISE  = 2'b01,
        EV_FALL  = 2'b10,
        EV_PULSE = 2'b11
    } ev_sel_e;

    typedef struct packed {
        logic level;
        logic rise;
        logic fall;
    } pin_evt_t;

    // Stop-after-first applies to the edge modes only.
    function automatic logic stop_effective(ev_sel_e sel, logic stop);
        return stop && (sel != EV_PULSE);
    endfunction

endpackage

// File: rtl/pcu_pin_sync.sv
module pcu_pin_sync
    import pcu_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     pin_raw,
    output pin_evt_t evt
);
    localparam int MSB = SYNC_STAGES - 1;

    logic [MSB:0] chain;
    logic         prev;

    generate
        if (SYNC_STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) chain <= '0;
                else     chain <= pin_raw;
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (rst) chain <= '0;
                else     chain <= {chain[MSB-1:0], pin_raw};
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) prev <= 1'b0;
        else     prev <= chain[MSB];
    end

    always_comb begin
        evt.level = chain[MSB];
        evt.rise  = chain[MSB] & ~prev;
        evt.fall  = ~chain[MSB] & prev;
    end

endmodule

// File: rtl/pcu_counter.sv
module pcu_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             count_en,
    input  logic             clr_ovf,
    output logic [CNT_W-1:0] cnt,
    output logic             ovf_flag
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic wrap;

    assign wrap = count_en && (cnt == CNT_MAX);

    always_ff @(posedge clk) begin
        if (rst)           cnt <= '0;
        else if (count_en) cnt <= cnt + 1'b1;
    end

    // A wrap wins over a simultaneous clear.
    always_ff @(posedge clk) begin
        if (rst)          ovf_flag <= 1'b0;
        else if (wrap)    ovf_flag <= 1'b1;
        else if (clr_ovf) ovf_flag <= 1'b0;
    end

endmodule

// File: rtl/pcu_capture_core.sv
module pcu_capture_core
    import pcu_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  pin_evt_t         evt,
    input  ev_sel_e          sel,
    input  logic             stop_mode,
    input  logic             clr_cap,
    input  logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] capture_val,
    output logic             cap_flag
);
    logic [CNT_W-1:0] start_cnt;
    logic             armed;
    logic             hit_edge;
    logic             hit_pulse;
    logic             blocked;
    logic             accept;
    logic [CNT_W-1:0] next_val;

    always_comb begin
        hit_edge  = ((sel == EV_RISE) && evt.rise) ||
                    ((sel == EV_FALL) && evt.fall);
        hit_pulse = (sel == EV_PULSE) && evt.fall && armed;
        blocked   = stop_effective(sel, stop_mode) && cap_flag && !clr_cap;
        accept    = (hit_edge || hit_pulse) && !blocked;
        next_val  = (sel == EV_PULSE) ? (cnt - start_cnt) : cnt;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            start_cnt <= '0;
            armed     <= 1'b0;
        end else if ((sel == EV_PULSE) && evt.rise) begin
            start_cnt <= cnt;
            armed     <= 1'b1;
        end else if ((sel != EV_PULSE) || evt.fall) begin
            armed     <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)         capture_val <= '0;
        else if (accept) capture_val <= next_val;
    end

    always_ff @(posedge clk) begin
        if (rst)          cap_flag <= 1'b0;
        else if (accept)  cap_flag <= 1'b1;
        else if (clr_cap) cap_flag <= 1'b0;
    end

endmodule

// File: rtl/pulse_capture_unit.sv
module pulse_capture_unit
    import pcu_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             count_en,
    input  logic             pin_raw,
    input  logic [1:0]       ev_sel,
    input  logic             stop_mode,
    input  logic             clr_cap,
    input  logic             clr_ovf,
    output logic [CNT_W-1:0] count_val,
    output logic [CNT_W-1:0] capture_val,
    output logic             pin_level,
    output logic             cap_flag,
    output logic             ovf_flag
);
    pin_evt_t evt;
    ev_sel_e  sel;

    assign sel       = ev_sel_e'(ev_sel);
    assign pin_level = evt.level;

    pcu_pin_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .pin_raw (pin_raw),
        .evt     (evt)
    );

    pcu_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .count_en (count_en),
        .clr_ovf  (clr_ovf),
        .cnt      (count_val),
        .ovf_flag (ovf_flag)
    );

    pcu_capture_core #(.CNT_W(CNT_W)) u_core (
        .clk         (clk),
        .rst         (rst),
        .evt         (evt),
        .sel         (sel),
        .stop_mode   (stop_mode),
        .clr_cap     (clr_cap),
        .cnt         (count_val),
        .capture_val (capture_val),
        .cap_flag    (cap_flag)
    );

endmodule

// File: rtl/pcu_checker.sv
module pcu_checker #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             count_en,
    input logic [1:0]       ev_sel,
    input logic             stop_mode,
    input logic             clr_cap,
    input logic             clr_ovf,
    input logic [CNT_W-1:0] count_val,
    input logic [CNT_W-1:0] capture_val,
    input logic             cap_flag,
    input logic             ovf_flag
);
    // R2: a changed capture value always comes with the flag set
    p_capture_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (capture_val != $past(capture_val)) |-> cap_flag);

    // R4: disabled mode leaves the flag and value alone
    p_off_quiet_r4: assert property (@(posedge clk) disable iff (rst)
        (ev_sel == 2'b00 && !cap_flag) |=> (!cap_flag && $stable(capture_val)));

    // R7: locked stop mode keeps the captured value
    p_stop_lock_r7: assert property (@(posedge clk) disable iff (rst)
        (stop_mode && ev_sel != 2'b11 && cap_flag && !clr_cap)
            |=> ($stable(capture_val) && cap_flag));

    // R9: flag is sticky without a clear strobe
    p_flag_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        (cap_flag && !clr_cap) |=> cap_flag);

    // R10: wrap sets the overflow flag, even against a clear
    p_wrap_sets_r10: assert property (@(posedge clk) disable iff (rst)
        (count_en && count_val == {CNT_W{1'b1}}) |=> ovf_flag);

    // R10: overflow flag is sticky
    p_ovf_sticky_r10: assert property (@(posedge clk) disable iff (rst)
        (ovf_flag && !clr_ovf) |=> ovf_flag);

    // R10: counter holds while disabled
    p_count_hold_r10: assert property (@(posedge clk) disable iff (rst)
        !count_en |=> $stable(count_val));

endmodule

bind pulse_capture_unit pcu_checker #(.CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .count_en    (count_en),
    .ev_sel      (ev_sel),
    .stop_mode   (stop_mode),
    .clr_cap     (clr_cap),
    .clr_ovf     (clr_ovf),
    .count_val   (count_val),
    .capture_val (capture_val),
    .cap_flag    (cap_flag),
    .ovf_flag    (ovf_flag)
);

// File: tb/pulse_capture_unit_test.sv
`timescale 1ns/1ps
module pulse_capture_unit_test;

    logic        clk = 1'b0;
    logic        rst;
    logic        count_en;
    logic        pin_raw;
    logic [1:0]  ev_sel;
    logic        stop_mode;
    logic        clr_cap;
    logic        clr_ovf;
    logic [15:0] count_val;
    logic [15:0] capture_val;
    logic        pin_level;
    logic        cap_flag;
    logic        ovf_flag;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    pulse_capture_unit uut (
        .clk         (clk),
        .rst         (rst),
        .count_en    (count_en),
        .pin_raw     (pin_raw),
        .ev_sel      (ev_sel),
        .stop_mode   (stop_mode),
        .clr_cap     (clr_cap),
        .clr_ovf     (clr_ovf),
        .count_val   (count_val),
        .capture_val (capture_val),
        .pin_level   (pin_level),
        .cap_flag    (cap_flag),
        .ovf_flag    (ovf_flag)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic strobe_clr_cap();
        clr_cap = 1'b1; tick(1); clr_cap = 1'b0;
    endtask

    task automatic test_reset();
        check("R12 count", count_val, 0);
        check("R12 capture", capture_val, 0);
        check("R12 flags", {cap_flag, ovf_flag, pin_level}, 0);
    endtask

    task automatic test_rise();
        logic [15:0] c0, held;
        ev_sel = 2'b01; stop_mode = 1'b0;
        c0 = count_val; pin_raw = 1'b1;
        tick(1); check("R11 level lag", pin_level, 0);
        tick(1); check("R11 level", pin_level, 1);
        tick(1);
        check("R1 rise stamp", capture_val, c0 + 16'd2);
        check("R9 flag set", cap_flag, 1);
        held = capture_val;
        tick(6);
        check("R2 hold", capture_val, held);
        pin_raw = 1'b0; tick(4);
        check("R1 fall ignored", capture_val, held);
        check("R9 sticky", cap_flag, 1);
        strobe_clr_cap();
        check("R9 cleared", cap_flag, 0);
    endtask

    task automatic test_fall();
        logic [15:0] c0, c1;
        ev_sel = 2'b10; stop_mode = 1'b0;
        pin_raw = 1'b1; tick(4);
        check("R3 rise ignored", cap_flag, 0);
        c0 = count_val; pin_raw = 1'b0; tick(3);
        check("R3 fall stamp", capture_val, c0 + 16'd2);
        pin_raw = 1'b1; tick(5);
        c1 = count_val; pin_raw = 1'b0; tick(3);
        check("R8 overwrite", capture_val, c1 + 16'd2);
        strobe_clr_cap();
    endtask

    task automatic test_stop();
        logic [15:0] c0, c2;
        ev_sel = 2'b01; stop_mode = 1'b1;
        c0 = count_val; pin_raw = 1'b1; tick(3);
        check("R7 first stamp", capture_val, c0 + 16'd2);
        pin_raw = 1'b0; tick(4);
        pin_raw = 1'b1; tick(4);
        check("R7 locked", capture_val, c0 + 16'd2);
        pin_raw = 1'b0; tick(4);
        c2 = count_val; pin_raw = 1'b1;
        tick(2); clr_cap = 1'b1; tick(1); clr_cap = 1'b0;
        check("R7 clear+event stamp", capture_val, c2 + 16'd2);
        check("R7 clear+event flag", cap_flag, 1);
        strobe_clr_cap();
        pin_raw = 1'b0; tick(4);
    endtask

    task automatic test_off();
        logic [15:0] held;
        ev_sel = 2'b00; stop_mode = 1'b0;
        held = capture_val;
        for (int i = 0; i < 3; i++) begin
            pin_raw = 1'b1; tick(3);
            pin_raw = 1'b0; tick(3);
        end
        check("R4 value", capture_val, held);
        check("R4 flag", cap_flag, 0);
    endtask

    task automatic test_pulse();
        ev_sel = 2'b11; stop_mode = 1'b1;
        pin_raw = 1'b1; tick(5);
        pin_raw = 1'b0; tick(3);
        check("R5 width 5", capture_val, 5);
        check("R5 flag", cap_flag, 1);
        pin_raw = 1'b1; tick(3);
        check("R5 rise stores nothing", capture_val, 5);
        tick(6);
        pin_raw = 1'b0; tick(3);
        check("R6 width 9 despite stop", capture_val, 9);
        strobe_clr_cap();
        ev_sel = 2'b00; stop_mode = 1'b0;
    endtask

    task automatic wait_count(input logic [15:0] v);
        while (count_val !== v) tick(1);
    endtask

    task automatic test_ovf();
        count_en = 1'b1;
        wait_count(16'hFFFF);
        check("R10 not yet", ovf_flag, 0);
        tick(1);
        check("R10 wrap count", count_val, 0);
        check("R10 wrap flag", ovf_flag, 1);
        tick(3);
        check("R10 sticky", ovf_flag, 1);
        clr_ovf = 1'b1; tick(1); clr_ovf = 1'b0;
        check("R10 cleared", ovf_flag, 0);
        wait_count(16'hFFFF);
        count_en = 1'b0; tick(3);
        check("R10 frozen", count_val, 16'hFFFF);
        count_en = 1'b1; clr_ovf = 1'b1; tick(1);
        count_en = 1'b0; clr_ovf = 1'b0;
        check("R10 wrap beats clear", ovf_flag, 1);
        check("R10 count zero", count_val, 0);
    endtask

    initial begin
        rst = 1'b1; count_en = 1'b0; pin_raw = 1'b0; ev_sel = 2'b00;
        stop_mode = 1'b0; clr_cap = 1'b0; clr_ovf = 1'b0;
        tick(3);
        test_reset();
        rst = 1'b0; count_en = 1'b1;
        tick(2);
        test_rise();
        test_fall();
        test_stop();
        test_off();
        test_pulse();
        test_ovf();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule